// File: doc/BRIEF.md
# Three-Multiplier Pipelined Complex Multiplier

This block multiplies two complex fixed-point numbers, (A + jB) times (C + jD), using three real multipliers instead of the usual four. One product, B(C−D), is formed once and feeds both outputs. The real result is built as C(A−B) + B(C−D) and the imaginary result as D(A+B) + B(C−D). All parts are signed two's complement.

The datapath is fully pipelined with six register stages, so it accepts a new operand pair on every clock. A valid strobe travels alongside the data. A pipeline stage loads only when the data entering it is valid. The result width is a parameter. At its default the result keeps full precision. A narrower setting keeps only the upper bits.

Top module: `cplx_mul3`

## Requirements
- R1: When `outValid` is high, `outRe` equals A·C − B·D, computed exactly from the operand pair that produced it, at full width (2·IN_W+2 bits).
- R2: When `outValid` is high, `outIm` equals A·D + B·C, computed exactly from the same operand pair.
- R3: Operands that all sit at the most negative value (−2^(IN_W−1)) produce the exact product with no wraparound. For IN_W = 16 that product is real 0 and imaginary 2^31.
- R4: A new operand pair is accepted on every rising edge. A run of back-to-back valid inputs gives a run of back-to-back valid results, each matching its own input.
- R5: An operand pair sampled with `inValid` high at rising edge n appears on the outputs, with `outValid` high, right after rising edge n+5. Before that edge the outputs do not show it.
- R6: `outValid` is `inValid` delayed by the same six stages. Gaps in the input stream show up as gaps of the same length and position in the output stream.
- R7: Operands presented with `inValid` low are ignored. While `outValid` is low, `outRe` and `outIm` hold the last valid result (or zero if no valid result has appeared since reset).
- R8: While `rstN` is low, `outValid`, `outRe` and `outIm` are zero. Operands that were in flight when reset was asserted never reach the outputs.
- R9: With OUT_W smaller than 2·IN_W+2, each output equals the full-precision result shifted right arithmetically by (2·IN_W+2 − OUT_W) bits. This is truncation toward minus infinity.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rstN | input | 1 | Asynchronous reset, active low |
| inValid | input | 1 | High when the operand pair on inA..inD is to be processed |
| inA | input | IN_W | Real part of the first operand, signed |
| inB | input | IN_W | Imaginary part of the first operand, signed |
| inC | input | IN_W | Real part of the second operand, signed |
| inD | input | IN_W | Imaginary part of the second operand, signed |
| outValid | output | 1 | High when outRe/outIm carry a new product |
| outRe | output | OUT_W | Real part of the product, signed |
| outIm | output | OUT_W | Imaginary part of the product, signed |

## Verification
The latency and gap properties assume that `inValid` is a known 0 or 1 from the first clock edge on. They also assume it stays low while reset is held, so that no stale strobe is mistaken for an accepted operand. The bench drives `inValid` low from time zero and through every reset phase. It changes operands only on falling edges. The arithmetic checks compare against the four-multiply formula. The stimulus mixes all-extreme operands, sign mixes and gaps. During gaps the operand values are deliberately nonzero, so an ignored input that leaked through would show up on the held outputs.

// File: rtl/cmul3_pkg.sv
package cmul3_pkg;

  // Number of register stages between the input pins and the output pins.
  localparam int unsigned PIPE_DEPTH = 6;

  // Strobes that the control sends to the datapath: one load enable per
  // stage (index 0 is the input capture stage), plus the output valid flag.
  typedef struct packed {
    logic [PIPE_DEPTH-1:0] load;
    logic                  outValid;
  } cmul3_strobe_t;

  // Width at which both products and sums are exact for signed inputs.
  function automatic int fullWidth(input int inW);
    return 2 * inW + 2;
  endfunction

endpackage

// File: rtl/cmul3_ctrl.sv
module cmul3_ctrl
  import cmul3_pkg::*;
(
  input  logic          clk,
  input  logic          rstN,
  input  logic          inValid,
  output cmul3_strobe_t strobe
);

  localparam int unsigned DEPTH = PIPE_DEPTH;

  // validPipe[k] is high when stage k holds an accepted operand pair.
  logic [DEPTH-1:0] validPipe;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      validPipe <= '0;
    end else begin
      validPipe <= {validPipe[DEPTH-2:0], inValid};
    end
  end

  // Stage k loads when the data presented to it is valid.
  always_comb begin
    strobe.load     = {validPipe[DEPTH-2:0], inValid};
    strobe.outValid = validPipe[DEPTH-1];
  end

  // R5: an accepted pair surfaces six edges later.
  a_r5_latency: assert property (@(posedge clk) disable iff (!rstN)
    inValid |-> ##6 strobe.outValid);

  // R6: an input gap yields an output gap at the same distance.
  a_r6_gap: assert property (@(posedge clk) disable iff (!rstN)
    !inValid |-> ##6 !strobe.outValid);

endmodule

// File: rtl/cmul3_datapath.sv
module cmul3_datapath
  import cmul3_pkg::*;
#(
  parameter int IN_W  = 16,
  parameter int OUT_W = 2 * IN_W + 2
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  cmul3_strobe_t           strobe,
  input  logic signed [IN_W-1:0]  inA,
  input  logic signed [IN_W-1:0]  inB,
  input  logic signed [IN_W-1:0]  inC,
  input  logic signed [IN_W-1:0]  inD,
  output logic signed [OUT_W-1:0] outRe,
  output logic signed [OUT_W-1:0] outIm
);

  localparam int PRE_W  = IN_W + 1;        // pre-adder result width
  localparam int PROD_W = IN_W + PRE_W;    // each real product
  localparam int FULL_W = fullWidth(IN_W); // final sums
  localparam int SHIFT  = FULL_W - OUT_W;  // dropped low bits

  // ---------------- stage 1: operand capture ----------------
  logic signed [IN_W-1:0] aR, bR, cR, dR;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      aR <= '0;
      bR <= '0;
      cR <= '0;
      dR <= '0;
    end else if (strobe.load[0]) begin
      aR <= inA;
      bR <= inB;
      cR <= inC;
      dR <= inD;
    end
  end

  // ---------------- stage 2: three pre-adders ----------------
  logic signed [PRE_W-1:0] aMinusB, aPlusB, cMinusD;
  logic signed [IN_W-1:0]  bS2, cS2, dS2;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      aMinusB <= '0;
      aPlusB  <= '0;
      cMinusD <= '0;
      bS2     <= '0;
      cS2     <= '0;
      dS2     <= '0;
    end else if (strobe.load[1]) begin
      aMinusB <= PRE_W'(aR) - PRE_W'(bR);
      aPlusB  <= PRE_W'(aR) + PRE_W'(bR);
      cMinusD <= PRE_W'(cR) - PRE_W'(dR);
      bS2     <= bR;
      cS2     <= cR;
      dS2     <= dR;
    end
  end

  // ---------------- stage 3: three real multipliers ----------------
  logic signed [PROD_W-1:0] prodReOnly, prodImOnly, prodShared;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      prodReOnly <= '0;
      prodImOnly <= '0;
      prodShared <= '0;
    end else if (strobe.load[2]) begin
      prodReOnly <= PROD_W'(cS2) * PROD_W'(aMinusB);
      prodImOnly <= PROD_W'(dS2) * PROD_W'(aPlusB);
      prodShared <= PROD_W'(bS2) * PROD_W'(cMinusD);
    end
  end

  // ---------------- stage 4: multiplier output register ----------------
  logic signed [PROD_W-1:0] prodReQ, prodImQ, prodShQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      prodReQ <= '0;
      prodImQ <= '0;
      prodShQ <= '0;
    end else if (strobe.load[3]) begin
      prodReQ <= prodReOnly;
      prodImQ <= prodImOnly;
      prodShQ <= prodShared;
    end
  end

  // ---------------- stage 5: two post-adders sharing one product ----------------
  logic signed [FULL_W-1:0] sumRe, sumIm;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sumRe <= '0;
      sumIm <= '0;
    end else if (strobe.load[4]) begin
      sumRe <= FULL_W'(prodReQ) + FULL_W'(prodShQ);
      sumIm <= FULL_W'(prodImQ) + FULL_W'(prodShQ);
    end
  end

  // ---------------- output width selection ----------------
  logic signed [OUT_W-1:0] trRe, trIm;

  generate
    if (SHIFT == 0) begin : g_full
      assign trRe = sumRe;
      assign trIm = sumIm;
    end else begin : g_trunc
      assign trRe = sumRe[FULL_W-1 -: OUT_W];
      assign trIm = sumIm[FULL_W-1 -: OUT_W];
    end
  endgenerate

  // ---------------- stage 6: output register ----------------
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      outRe <= '0;
      outIm <= '0;
    end else if (strobe.load[5]) begin
      outRe <= trRe;
      outIm <= trIm;
    end
  end

  // ---------------- assertions ----------------
  // Reference product in the four-multiply form, taken from stage 1.
  logic signed [FULL_W-1:0] refRe, refIm;
  assign refRe = FULL_W'(aR) * FULL_W'(cR) - FULL_W'(bR) * FULL_W'(dR);
  assign refIm = FULL_W'(aR) * FULL_W'(dR) + FULL_W'(bR) * FULL_W'(cR);

  // R1: the three-multiplier real sum matches the textbook product.
  a_r1_real_exact: assert property (@(posedge clk) disable iff (!rstN)
    strobe.load[5] |-> sumRe == $past(refRe, 4));

  // R2: the imaginary sum matches as well.
  a_r2_imag_exact: assert property (@(posedge clk) disable iff (!rstN)
    strobe.load[5] |-> sumIm == $past(refIm, 4));

  // R7: outputs hold while no valid result leaves the last stage.
  a_r7_hold: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.load[5] |=> ($stable(outRe) && $stable(outIm)));

endmodule

// File: rtl/cplx_mul3.sv
module cplx_mul3
  import cmul3_pkg::*;
#(
  parameter int IN_W  = 16,
  parameter int OUT_W = 2 * IN_W + 2
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  logic                    inValid,
  input  logic signed [IN_W-1:0]  inA,
  input  logic signed [IN_W-1:0]  inB,
  input  logic signed [IN_W-1:0]  inC,
  input  logic signed [IN_W-1:0]  inD,
  output logic                    outValid,
  output logic signed [OUT_W-1:0] outRe,
  output logic signed [OUT_W-1:0] outIm
);

  cmul3_strobe_t strobe;

  cmul3_ctrl u_ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .inValid (inValid),
    .strobe  (strobe)
  );

  cmul3_datapath #(
    .IN_W  (IN_W),
    .OUT_W (OUT_W)
  ) u_dp (
    .clk    (clk),
    .rstN   (rstN),
    .strobe (strobe),
    .inA    (inA),
    .inB    (inB),
    .inC    (inC),
    .inD    (inD),
    .outRe  (outRe),
    .outIm  (outIm)
  );

  assign outValid = strobe.outValid;

endmodule

// File: tb/sim_cplx_mul3.sv
`timescale 1ns/1ps
module sim_cplx_mul3;

  localparam int IW    = 16;
  localparam int FW    = 2 * IW + 2;
  localparam int TW    = 16;
  localparam int TSH   = FW - TW;
  localparam int NV    = 16;
  localparam int LAT   = 6;
  localparam int IDX_MN = 5; // table entry with all operands most negative

  // {valid, A, B, C, D}
  localparam logic [64:0] TBL [NV] = '{
    {1'b1, 16'sd1,    16'sd2,    16'sd3,    16'sd4},
    {1'b1, 16'sd0,    16'sd0,    16'sd0,    16'sd0},
    {1'b1, 16'h7FFF,  16'h7FFF,  16'h7FFF,  16'h7FFF},
    {1'b1, 16'hFFFF,  16'sd1,    16'hFFFF,  16'sd1},
    {1'b1, 16'sd1234, 16'hF000,  16'sd77,   16'hFF85},
    {1'b1, 16'h8000,  16'h8000,  16'h8000,  16'h8000},
    {1'b0, 16'h5A5A,  16'h1234,  16'h7777,  16'h0F0F},
    {1'b1, 16'h8000,  16'h7FFF,  16'h7FFF,  16'h8000},
    {1'b0, 16'h3333,  16'h4444,  16'h5555,  16'h6666},
    {1'b0, 16'h0101,  16'h0202,  16'h0303,  16'h0404},
    {1'b1, 16'sd300,  16'hFED4,  16'sd500,  16'sd600},
    {1'b1, 16'h8000,  16'sd0,    16'sd0,    16'h8000},
    {1'b1, 16'sd9,    16'hFFF7,  16'hFFEE,  16'sd17},
    {1'b1, 16'h7FFF,  16'h8000,  16'h8000,  16'h7FFF},
    {1'b0, 16'hBEEF,  16'hCAFE,  16'h1357,  16'h2468},
    {1'b1, 16'sd5,    16'sd0,    16'sd0,    16'sd7}
  };

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic rstN;
  logic inValid;
  logic signed [IW-1:0] a, b, c, d;
  logic outValid, trValid;
  logic signed [FW-1:0] outRe, outIm;
  logic signed [TW-1:0] trRe, trIm;

  cplx_mul3 #(.IN_W(IW), .OUT_W(FW)) u0 (
    .clk(clk), .rstN(rstN), .inValid(inValid),
    .inA(a), .inB(b), .inC(c), .inD(d),
    .outValid(outValid), .outRe(outRe), .outIm(outIm)
  );

  cplx_mul3 #(.IN_W(IW), .OUT_W(TW)) u1 (
    .clk(clk), .rstN(rstN), .inValid(inValid),
    .inA(a), .inB(b), .inC(c), .inD(d),
    .outValid(trValid), .outRe(trRe), .outIm(trIm)
  );

  int  nRun  = 0;
  int  nFail = 0;
  bit  done  = 1'b0;

  task automatic chk(input string req, input longint act, input longint exp);
    nRun++;
    if (act != exp) begin
      nFail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic longint fld(input int i, input int hi);
    logic signed [IW-1:0] v;
    v = TBL[i][hi -: IW];
    return longint'(v);
  endfunction

  longint expRe [NV];
  longint expIm [NV];

  initial begin
    longint lastRe, lastIm;
    rstN = 1'b0; inValid = 1'b0; a = '0; b = '0; c = '0; d = '0;

    // Four-multiply reference
    for (int i = 0; i < NV; i++) begin
      expRe[i] = fld(i, 63) * fld(i, 31) - fld(i, 47) * fld(i, 15);
      expIm[i] = fld(i, 63) * fld(i, 15) + fld(i, 47) * fld(i, 31);
    end

    // R8: reset state
    repeat (3) @(negedge clk);
    chk("R8 reset outValid", longint'(outValid), 0);
    chk("R8 reset outRe", longint'(outRe), 0);
    chk("R8 reset outIm", longint'(outIm), 0);
    @(negedge clk);
    rstN = 1'b1;

    // Streamed vector table
    lastRe = 0; lastIm = 0;
    for (int k = 0; k < NV + LAT; k++) begin
      @(negedge clk);
      if (k >= LAT) begin
        int j;
        j = k - LAT;
        chk("R4 R6 outValid", longint'(outValid), longint'(TBL[j][64]));
        if (TBL[j][64]) begin
          lastRe = expRe[j];
          lastIm = expIm[j];
          chk("R1 real", longint'(outRe), lastRe);
          chk("R2 imag", longint'(outIm), lastIm);
          if (j == IDX_MN) begin
            chk("R3 most-negative real", longint'(outRe), 0);
            chk("R3 most-negative imag", longint'(outIm), longint'(1) <<< 31);
          end
        end else begin
          chk("R7 hold real", longint'(outRe), lastRe);
          chk("R7 hold imag", longint'(outIm), lastIm);
        end
        chk("R9 trunc real", longint'(trRe), lastRe >>> TSH);
        chk("R9 trunc imag", longint'(trIm), lastIm >>> TSH);
      end else begin
        chk("R5 not yet valid", longint'(outValid), 0);
      end
      if (k < NV) begin
        inValid = TBL[k][64];
        a = TBL[k][63:48]; b = TBL[k][47:32];
        c = TBL[k][31:16]; d = TBL[k][15:0];
      end else begin
        inValid = 1'b0;
        a = 16'h1111; b = 16'h2222; c = 16'h3333; d = 16'h4444;
      end
    end

    // R7: long idle with changing garbage operands
    for (int k = 0; k < 8; k++) begin
      @(negedge clk);
      a = 16'(k * 911); b = 16'(k * 37); c = 16'h8000; d = 16'(k);
      chk("R7 idle outValid", longint'(outValid), 0);
      chk("R7 idle real", longint'(outRe), lastRe);
    end

    // R8: reset while data is in flight
    @(negedge clk);
    inValid = 1'b1; a = 16'sd100; b = 16'sd200; c = 16'sd300; d = 16'sd400;
    repeat (3) @(negedge clk);
    inValid = 1'b0;
    rstN = 1'b0;
    @(negedge clk);
    chk("R8 mid reset outValid", longint'(outValid), 0);
    chk("R8 mid reset outRe", longint'(outRe), 0);
    chk("R8 mid reset outIm", longint'(outIm), 0);
    rstN = 1'b1;
    for (int k = 0; k < 8; k++) begin
      @(negedge clk);
      chk("R8 flushed outValid", longint'(outValid), 0);
    end
    chk("R8 flushed outRe", longint'(outRe), 0);

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", nRun, nFail);
    $finish;
  end

  // Watchdog
  initial begin
    #(4 * 20000);
    if (!done) begin
      nRun++;
      nFail++;
      $display("FAIL watchdog R5 actual=%0d expected=%0d", 0, 1);
      $display("  [TB] %0d tests run, %0d failed", nRun, nFail);
      $finish;
    end
  end

endmodule